// File: doc/BRIEF.md
# Manchester Carry Chain Adder

This block adds two unsigned WIDTH-bit operands and a carry input without any clock. It produces a WIDTH-bit sum and a carry output. The carry path is a chain of switch-like stages. Each stage derives three control lines from its pair of operand bits: generate, propagate and kill. Exactly one of the three is active. The active control forces the stage's carry output high, passes the incoming carry along, or forces the output low. It does this by selection, without an AND-OR carry equation.

A parameter selects the polarity of the chain. In the true-polarity form every link carries the carry itself. In the inverted form every link carries the complement of the carry, and each stage needs only generate and propagate. The two forms give the same sum and carry output for every input. The per-stage control lines are driven to output ports so that a surrounding environment can observe them.

Top module: `mcc_adder`

## Requirements
- R1: `stage_gen[i]` is high exactly when `opa[i]` and `opb[i]` are both 1.
- R2: `stage_prop[i]` is high exactly when `opa[i]` and `opb[i]` differ.
- R3: `stage_kill[i]` is high exactly when `opa[i]` and `opb[i]` are both 0.
- R4: In every stage i, exactly one of `stage_gen[i]`, `stage_prop[i]` and `stage_kill[i]` is high. Generate and propagate are never high together.
- R5: `sum` equals the low WIDTH bits of opa + opb + cin, with all values taken as unsigned.
- R6: `cout` equals bit WIDTH of opa + opb + cin.
- R7: With POLARITY set to inverted, `sum` and `cout` match the true-polarity build for every input.
- R8: A carry entering stage 0 travels the whole chain when every stage propagates. For example, opa = all ones, opb = 0 and cin = 1 give sum = 0 and cout = 1.
- R9: With zero operands and cin = 0, the outputs are sum = 0, cout = 0, every kill bit = 1, and every generate and propagate bit = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand |
| cin | input | 1 | Carry into stage 0 |
| sum | output | WIDTH | Sum bits |
| cout | output | 1 | Carry out of the last stage |
| stage_gen | output | WIDTH | Per-stage generate control |
| stage_prop | output | WIDTH | Per-stage propagate control |
| stage_kill | output | WIDTH | Per-stage kill control |

## Verification
The assertions are immediate checks that re-evaluate whenever the inputs change. They assume that the operand and carry inputs are fully driven, and that the outputs are read only after the combinational chain has settled. The bench meets both assumptions. It drives every input from a single process and waits a fixed settling time before it samples. It sweeps every operand pair and both carry-in values at the default width, on a true-polarity instance and an inverted-polarity instance side by side.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
   typedef enum logic {
      POL_TRUE     = 1'b0,
      POL_INVERTED = 1'b1
   } chain_pol_e;
endpackage

// File: rtl/mcc_stage_ctl.sv
module mcc_stage_ctl (
   input  logic a_i,
   input  logic b_i,
   output logic gen_o,
   output logic prop_o,
   output logic kill_o
);
   assign gen_o  = a_i & b_i;
   assign prop_o = a_i ^ b_i;
   assign kill_o = ~(a_i | b_i);
endmodule

// File: rtl/mcc_cell_true.sv
module mcc_cell_true (
   input  logic gen_i,
   input  logic prop_i,
   input  logic kill_i,
   input  logic c_i,
   output logic c_o
);
   always_comb begin
      unique case ({gen_i, prop_i, kill_i})
         3'b100:  c_o = 1'b1;
         3'b010:  c_o = c_i;
         3'b001:  c_o = 1'b0;
         default: c_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/mcc_cell_inv.sv
module mcc_cell_inv (
   input  logic gen_i,
   input  logic prop_i,
   input  logic cn_i,
   output logic cn_o
);
   always_comb begin
      if (prop_i) cn_o = cn_i;
      else        cn_o = ~gen_i;
   end
endmodule

// File: rtl/mcc_adder.sv
module mcc_adder #(
   parameter int                 WIDTH    = 8,
   parameter mcc_pkg::chain_pol_e POLARITY = mcc_pkg::POL_TRUE
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cout,
   output logic [WIDTH-1:0] stage_gen,
   output logic [WIDTH-1:0] stage_prop,
   output logic [WIDTH-1:0] stage_kill
);
   localparam int LAST = WIDTH - 1;

   logic [WIDTH:0] carry;

   if (WIDTH < 1) begin : g_bad_width
      $error("mcc_adder: WIDTH must be at least 1");
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_ctl
      mcc_stage_ctl u_ctl (
         .a_i   (opa[i]),
         .b_i   (opb[i]),
         .gen_o (stage_gen[i]),
         .prop_o(stage_prop[i]),
         .kill_o(stage_kill[i])
      );
   end

   if (POLARITY == mcc_pkg::POL_TRUE) begin : g_true
      assign carry[0] = cin;
      for (genvar i = 0; i < WIDTH; i++) begin : g_link
         mcc_cell_true u_cell (
            .gen_i (stage_gen[i]),
            .prop_i(stage_prop[i]),
            .kill_i(stage_kill[i]),
            .c_i   (carry[i]),
            .c_o   (carry[i+1])
         );
      end
   end else begin : g_inv
      logic [WIDTH:0] carry_n;
      assign carry_n[0] = ~cin;
      for (genvar i = 0; i < WIDTH; i++) begin : g_link
         mcc_cell_inv u_cell (
            .gen_i (stage_gen[i]),
            .prop_i(stage_prop[i]),
            .cn_i  (carry_n[i]),
            .cn_o  (carry_n[i+1])
         );
      end
      assign carry = ~carry_n;
   end

   assign sum  = stage_prop ^ carry[LAST:0];
   assign cout = carry[WIDTH];
endmodule

// File: rtl/mcc_adder_chk.sv
module mcc_adder_chk #(
   parameter int WIDTH = 8
) (
   input logic [WIDTH-1:0] opa,
   input logic [WIDTH-1:0] opb,
   input logic             cin,
   input logic [WIDTH-1:0] sum,
   input logic             cout,
   input logic [WIDTH-1:0] stage_gen,
   input logic [WIDTH-1:0] stage_prop,
   input logic [WIDTH-1:0] stage_kill
);
   logic [WIDTH:0] ref_total;
   assign ref_total = {1'b0, opa} + {1'b0, opb} + {{WIDTH{1'b0}}, cin};

   always_comb begin
      for (int i = 0; i < WIDTH; i++) begin
         assert_ctl_onehot_R4: assert ($onehot({stage_gen[i], stage_prop[i], stage_kill[i]}))
            else $error("stage %0d controls not one-hot", i);
      end
      assert_gen_prop_excl_R4: assert ((stage_gen & stage_prop) == '0)
         else $error("generate and propagate overlap");
      assert_gen_R1: assert (stage_gen == (opa & opb))
         else $error("generate mismatch");
      assert_kill_R3: assert (stage_kill == ~(opa | opb))
         else $error("kill mismatch");
      assert_sum_R5: assert (sum == ref_total[WIDTH-1:0])
         else $error("sum mismatch");
      assert_cout_R6: assert (cout == ref_total[WIDTH])
         else $error("carry out mismatch");
   end
endmodule

bind mcc_adder mcc_adder_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/mcc_adder_bench.sv
module mcc_adder_bench;
   localparam int W = 8;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #5 clk = ~clk;

   logic [W-1:0] opa, opb;
   logic         cin;
   logic [W-1:0] sum_t, sum_i, gen_t, prop_t, kill_t, gen_i, prop_i, kill_i;
   logic         cout_t, cout_i;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit done   = 1'b0;

   mcc_adder #(.WIDTH(W), .POLARITY(mcc_pkg::POL_TRUE)) u_mcc_adder (
      .opa(opa), .opb(opb), .cin(cin), .sum(sum_t), .cout(cout_t),
      .stage_gen(gen_t), .stage_prop(prop_t), .stage_kill(kill_t));

   mcc_adder #(.WIDTH(W), .POLARITY(mcc_pkg::POL_INVERTED)) u_mcc_adder_inv (
      .opa(opa), .opb(opb), .cin(cin), .sum(sum_i), .cout(cout_i),
      .stage_gen(gen_i), .stage_prop(prop_i), .stage_kill(kill_i));

   task automatic chk(input string req, input logic [W:0] act, input logic [W:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         if (fails < 20)
            $display("FAIL %s a=%0h b=%0h cin=%0b actual=%0h expected=%0h",
                     req, opa, opb, cin, act, exp);
      end
   endtask

   task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic c);
      logic [W:0] tot;
      opa = a; opb = b; cin = c;
      #2;
      tot = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
      chk("R1 gen",   {1'b0, gen_t},  {1'b0, a & b});
      chk("R2 prop",  {1'b0, prop_t}, {1'b0, a ^ b});
      chk("R3 kill",  {1'b0, kill_t}, {1'b0, ~(a | b)});
      chk("R4 onehot", {1'b0, (gen_t & prop_t) | (gen_t & kill_t) | (prop_t & kill_t)}, '0);
      chk("R4 cover", {1'b0, gen_t | prop_t | kill_t}, {1'b0, {W{1'b1}}});
      chk("R5 sum",   {1'b0, sum_t},  {1'b0, tot[W-1:0]});
      chk("R6 cout",  {{W{1'b0}}, cout_t}, {{W{1'b0}}, tot[W]});
      chk("R7 inv sum",  {cout_i, sum_i}, tot);
      chk("R7 inv ctl",  {1'b0, gen_i ^ gen_t}, '0);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      opa = '0; opb = '0; cin = 1'b0;
      #23 rst = 1'b0;
      // R9: all-zero inputs
      #2;
      chk("R9 sum", {cout_t, sum_t}, '0);
      chk("R9 kill", {1'b0, kill_t}, {1'b0, {W{1'b1}}});
      chk("R9 gp", {1'b0, gen_t | prop_t}, '0);
      // R8: full-length propagation, both polarities
      apply({W{1'b1}}, '0, 1'b1);
      chk("R8 ripple true", {cout_t, sum_t}, {1'b1, {W{1'b0}}});
      chk("R8 ripple inv",  {cout_i, sum_i}, {1'b1, {W{1'b0}}});
      apply('0, {W{1'b1}}, 1'b1);
      chk("R8 ripple b", {cout_t, sum_t}, {1'b1, {W{1'b0}}});
      apply({W{1'b1}}, '0, 1'b0);
      chk("R8 no carry", {cout_t, sum_t}, {1'b0, {W{1'b1}}});
      // exhaustive sweep: R1..R7
      for (int a = 0; a < (1 << W); a++)
         for (int b = 0; b < (1 << W); b++)
            for (int c = 0; c < 2; c++)
               apply(a[W-1:0], b[W-1:0], c[0]);
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule